// File: doc/BRIEF.md
# Configurable-Format Serial Receiver

This block turns an asynchronous serial input line into characters and queues them for a consumer. An external rate generator supplies a strobe, `tick_i`, at sixteen times the bit rate. The receiver hunts for a start bit and checks it at mid-bit. It then assembles 6, 7 or 8 data bits, least significant bit first. It checks an optional parity bit and one or two stop bits. Each finished character goes into a 16-entry first-word-fall-through queue, together with three flags: parity error, framing error and line break.

The consumer reads the character at the head of the queue and pops it with `rd_i`. Two outputs tell the consumer when to act. The fill watermark output `trig_o` reports that the queue holds at least a programmed number of entries. The idle timeout output `tmo_o` reports that characters are waiting and the line has been quiet for a programmed time. Enable, disable and flush inputs control the receiver. The line format comes from an 8-bit mode input.

Top module: `uart_rx_engine`

## Requirements
- R1: Data length follows `mode_i[2:1]`: 00 gives 8 bits, 10 gives 7 bits, 11 gives 6 bits (01 behaves as 8). Bits are taken least significant first. Unused upper bits of `rd_data_o` read as zero.
- R2: Parity follows `mode_i[5:3]`: 000 even, 001 odd, 010 bit forced to 0, 011 bit forced to 1, and 1xx means no parity bit is present. If the received parity bit differs from the expected value, the character is stored with `rd_par_err_o` = 1.
- R3: `mode_i[7]` = 1 selects two stop bits and 0 selects one (`mode_i[6]` is ignored). If any stop bit is sampled low, the character is stored with `rd_frm_err_o` = 1.
- R4: A character with a framing error and all-zero data is stored with `rd_brk_o` = 1. After any framing error, the receiver waits for the line to return high before it looks for a new start bit. A held-low line therefore yields exactly one entry.
- R5: Each bit is sampled 8 ticks after the start edge, then every 16 ticks. If the start bit is high again at its mid-point, it is discarded and nothing is stored.
- R6: The queue holds 16 entries in arrival order. The head entry is visible on the read outputs while `empty_o` = 0. `rd_i` pops one entry, and `fill_o` gives the count.
- R7: If a character completes while the queue is full and no pop occurs in that cycle, the character is dropped. `overrun_o` then pulses for one cycle, and the queue contents and fill count stay unchanged.
- R8: `trig_o` is high in every cycle in which `fill_o` >= `trig_lvl_i`.
- R9: `tmo_o` goes high after `tmo_lim_i` × 64 ticks in which the receiver is idle and the queue is not empty. The count restarts when a character is stored, when an entry is popped, or when `tmo_restart_i` pulses. An empty queue clears `tmo_o`, and a limit of 0 disables the timeout.
- R10: After reset the receiver is disabled. `rx_en_i` enables it and `rx_dis_i` disables it; when both are high, disable wins. While disabled, line activity stores nothing.
- R11: `rx_rst_i` empties the queue and abandons any character in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Oversampling strobe, 16 per bit |
| rxd_i | input | 1 | Serial line, idle high |
| mode_i | input | 8 | Format: [2:1] length, [5:3] parity, [7] two stops |
| rx_en_i | input | 1 | Enable pulse |
| rx_dis_i | input | 1 | Disable pulse, wins over enable |
| rx_rst_i | input | 1 | Flush queue and abort receive |
| trig_lvl_i | input | 6 | Fill watermark |
| tmo_lim_i | input | 8 | Idle timeout in units of 4 bit times, 0 = off |
| tmo_restart_i | input | 1 | Restart the idle timeout |
| rd_i | input | 1 | Pop head entry |
| rd_data_o | output | 8 | Head character |
| rd_frm_err_o | output | 1 | Head framing error |
| rd_par_err_o | output | 1 | Head parity error |
| rd_brk_o | output | 1 | Head break flag |
| empty_o | output | 1 | Queue empty |
| fill_o | output | 5 | Entries held |
| trig_o | output | 1 | Fill at or above watermark |
| tmo_o | output | 1 | Idle timeout expired |
| overrun_o | output | 1 | One-cycle pulse on a dropped character |

## Verification
A bit counter or format decode that drifts shows up one character later. The entry at the head of the queue then carries shifted data, stray upper bits, or a false parity or framing flag. A stuck start-hunt shows as an extra or missing entry within one bit time of the disturbance. Queue pointer or count errors appear as wrong ordering, a wrong `fill_o` or a missed overrun pulse once the queue wraps or fills. A faulty idle counter moves the `tmo_o` rise away from its window of a few hundred cycles.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned CHAR_W = 8;

  typedef struct packed {
    logic              brk;
    logic              par_err;
    logic              frm_err;
    logic [CHAR_W-1:0] data;
  } rx_char_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_WAIT_HI
  } rx_state_e;
endpackage

// File: rtl/uart_rx_deframer.sv
module uart_rx_deframer
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR = 16
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     rxd_i,
  input  logic     run_i,
  input  logic     flush_i,
  input  logic [7:0] mode_i,
  output rx_char_t char_o,
  output logic     char_vld_o,
  output logic     idle_o
);
  localparam int unsigned TW  = $clog2(OSR);
  localparam int unsigned MID = OSR/2 - 1;

  logic          rxd_m, rxd_s;
  rx_state_e     state_q;
  logic [TW-1:0] tcnt_q;
  logic [2:0]    bidx_q;
  logic [CHAR_W-1:0] shreg_q;
  logic          stop2_q, frm_q, perr_q;
  logic [2:0]    last_bit;
  logic          par_en, exp_par, frm_n, unused_mode;

  assign unused_mode = mode_i[6] ^ mode_i[0];

  always_comb begin
    unique case (mode_i[2:1])
      2'b10:   last_bit = 3'd6;
      2'b11:   last_bit = 3'd5;
      default: last_bit = 3'd7;
    endcase
    unique case (mode_i[4:3])
      2'b00:   exp_par = ^shreg_q;
      2'b01:   exp_par = ~^shreg_q;
      2'b10:   exp_par = 1'b0;
      default: exp_par = 1'b1;
    endcase
  end
  assign par_en = ~mode_i[5];
  assign frm_n  = frm_q | ~rxd_s;
  assign idle_o = (state_q == ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rxd_m <= 1'b1;
      rxd_s <= 1'b1;
    end else begin
      rxd_m <= rxd_i;
      rxd_s <= rxd_m;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      tcnt_q     <= '0;
      bidx_q     <= '0;
      shreg_q    <= '0;
      stop2_q    <= 1'b0;
      frm_q      <= 1'b0;
      perr_q     <= 1'b0;
      char_o     <= '0;
      char_vld_o <= 1'b0;
    end else begin
      char_vld_o <= 1'b0;
      if (flush_i || !run_i) begin
        state_q <= ST_IDLE;
        tcnt_q  <= '0;
      end else if (tick_i) begin
        unique case (state_q)
          ST_IDLE: if (!rxd_s) begin
            state_q <= ST_START;
            tcnt_q  <= '0;
          end
          ST_START: begin
            if (tcnt_q == TW'(MID)) begin
              tcnt_q <= '0;
              if (rxd_s) state_q <= ST_IDLE;   // glitch, not a start bit
              else begin
                state_q <= ST_DATA;
                bidx_q  <= '0;
                shreg_q <= '0;
                frm_q   <= 1'b0;
                perr_q  <= 1'b0;
              end
            end else tcnt_q <= tcnt_q + 1'b1;
          end
          ST_DATA: begin
            if (tcnt_q == TW'(OSR-1)) begin
              tcnt_q          <= '0;
              shreg_q[bidx_q] <= rxd_s;
              if (bidx_q == last_bit) begin
                state_q <= par_en ? ST_PAR : ST_STOP;
                stop2_q <= mode_i[7];
              end else bidx_q <= bidx_q + 1'b1;
            end else tcnt_q <= tcnt_q + 1'b1;
          end
          ST_PAR: begin
            if (tcnt_q == TW'(OSR-1)) begin
              tcnt_q  <= '0;
              perr_q  <= (rxd_s != exp_par);
              state_q <= ST_STOP;
            end else tcnt_q <= tcnt_q + 1'b1;
          end
          ST_STOP: begin
            if (tcnt_q == TW'(OSR-1)) begin
              tcnt_q <= '0;
              if (stop2_q) begin
                stop2_q <= 1'b0;
                frm_q   <= frm_n;
              end else begin
                char_o.data    <= shreg_q;
                char_o.frm_err <= frm_n;
                char_o.par_err <= perr_q;
                char_o.brk     <= frm_n && (shreg_q == '0);
                char_vld_o     <= 1'b1;
                state_q        <= frm_n ? ST_WAIT_HI : ST_IDLE;
              end
            end else tcnt_q <= tcnt_q + 1'b1;
          end
          ST_WAIT_HI: if (rxd_s) state_q <= ST_IDLE;
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  a_r3_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    char_vld_o |=> !char_vld_o);
  a_r4_break_waits_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (char_vld_o && char_o.brk && !flush_i && run_i) |-> state_q != ST_START);
endmodule

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int unsigned DEPTH = 16,
  parameter int unsigned W     = 11,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned CW   = $clog2(DEPTH+1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [W-1:0]  din_i,
  input  logic          pop_i,
  output logic [W-1:0]  dout_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o,
  output logic          ovr_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic          do_pop, do_push;

  assign empty_o = (count_o == '0);
  assign full_o  = (count_o == CW'(DEPTH));
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full_o || do_pop);
  assign dout_o  = mem_q[rp_q];

  always_ff @(posedge clk_i) begin
    if (do_push && !flush_i) mem_q[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; count_o <= '0; ovr_o <= 1'b0;
    end else if (flush_i) begin
      wp_q <= '0; rp_q <= '0; count_o <= '0; ovr_o <= 1'b0;
    end else begin
      ovr_o <= push_i && !do_push;
      if (do_push) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (do_pop)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      if (do_push && !do_pop)      count_o <= count_o + 1'b1;
      else if (do_pop && !do_push) count_o <= count_o - 1'b1;
    end
  end

  a_r6_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CW'(DEPTH));
  a_r6_pop_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && !push_i && !empty_o && !flush_i) |=> count_o == $past(count_o) - 1'b1);
  a_r7_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !flush_i) |=> (count_o == CW'(DEPTH)) && ovr_o);
  a_r11_flush_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
endmodule

// File: rtl/uart_rx_idle_tmr.sv
module uart_rx_idle_tmr #(
  parameter int unsigned UNIT_TICKS = 64,
  parameter int unsigned LW         = 8,
  localparam int unsigned PW        = $clog2(UNIT_TICKS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          reload_i,
  input  logic          empty_i,
  input  logic          idle_i,
  input  logic [LW-1:0] limit_i,
  output logic          tmo_o
);
  logic [PW-1:0] pre_q;
  logic [LW-1:0] units_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0; units_q <= '0; tmo_o <= 1'b0;
    end else if (reload_i || empty_i) begin
      pre_q <= '0; units_q <= '0; tmo_o <= 1'b0;
    end else if (tick_i && idle_i && (limit_i != '0) && !tmo_o) begin
      if (pre_q == PW'(UNIT_TICKS-1)) begin
        pre_q   <= '0;
        units_q <= units_q + 1'b1;
        if ({1'b0, units_q} + 1'b1 >= {1'b0, limit_i}) tmo_o <= 1'b1;
      end else pre_q <= pre_q + 1'b1;
    end
  end

  a_r9_empty_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_i |=> !tmo_o);
  a_r9_zero_limit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (limit_i == '0 && !tmo_o) |=> !tmo_o);
endmodule

// File: rtl/uart_rx_engine.sv
module uart_rx_engine
  import uart_rx_pkg::*;
#(
  parameter int unsigned OSR        = 16,
  parameter int unsigned DEPTH      = 16,
  parameter int unsigned TMO_BITS   = 4,
  localparam int unsigned CW        = $clog2(DEPTH+1),
  localparam int unsigned EW        = $bits(rx_char_t)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          rxd_i,
  input  logic [7:0]    mode_i,
  input  logic          rx_en_i,
  input  logic          rx_dis_i,
  input  logic          rx_rst_i,
  input  logic [5:0]    trig_lvl_i,
  input  logic [7:0]    tmo_lim_i,
  input  logic          tmo_restart_i,
  input  logic          rd_i,
  output logic [7:0]    rd_data_o,
  output logic          rd_frm_err_o,
  output logic          rd_par_err_o,
  output logic          rd_brk_o,
  output logic          empty_o,
  output logic [CW-1:0] fill_o,
  output logic          trig_o,
  output logic          tmo_o,
  output logic          overrun_o
);
  logic     rx_on_q, char_vld, idle, full, reload;
  rx_char_t char_in, head;
  logic [EW-1:0] head_raw;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rx_on_q <= 1'b0;
    else if (rx_dis_i) rx_on_q <= 1'b0;
    else if (rx_en_i)  rx_on_q <= 1'b1;
  end

  uart_rx_deframer #(.OSR(OSR)) i_deframer (
    .clk_i, .rst_ni, .tick_i, .rxd_i,
    .run_i(rx_on_q), .flush_i(rx_rst_i), .mode_i,
    .char_o(char_in), .char_vld_o(char_vld), .idle_o(idle)
  );

  uart_rx_fifo #(.DEPTH(DEPTH), .W(EW)) i_fifo (
    .clk_i, .rst_ni, .flush_i(rx_rst_i),
    .push_i(char_vld), .din_i(char_in), .pop_i(rd_i),
    .dout_o(head_raw), .count_o(fill_o), .empty_o, .full_o(full),
    .ovr_o(overrun_o)
  );

  assign reload = rx_rst_i | char_vld | (rd_i & ~empty_o) | tmo_restart_i;

  uart_rx_idle_tmr #(.UNIT_TICKS(OSR*TMO_BITS), .LW(8)) i_idle_tmr (
    .clk_i, .rst_ni, .tick_i, .reload_i(reload), .empty_i(empty_o),
    .idle_i(idle), .limit_i(tmo_lim_i), .tmo_o
  );

  assign head         = rx_char_t'(head_raw);
  assign rd_data_o    = head.data;
  assign rd_frm_err_o = head.frm_err;
  assign rd_par_err_o = head.par_err;
  assign rd_brk_o     = head.brk;
  assign trig_o       = (32'(fill_o) >= 32'(trig_lvl_i));

  a_r10_dis_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dis_i |=> !rx_on_q);
  a_r10_no_rx_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_on_q |=> !char_vld);
  a_r7_overrun_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> $past(full));
endmodule

// File: tb/test_uart_rx_engine.sv
module test_uart_rx_engine;
  logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, rxd = 1'b1;
  logic [7:0] mode = 8'h20;
  logic       rx_en = 0, rx_dis = 0, rx_rst = 0, tmo_rst = 0, rd = 0;
  logic [5:0] trig_lvl = 6'd1;
  logic [7:0] tmo_lim = 8'd0;
  logic [7:0] rd_data;
  logic       frm, perr, brk, empty, trig, tmo, ovr;
  logic [4:0] fill;
  int n_chk = 0, n_bad = 0, ovr_cnt = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_rx_engine i_uart_rx_engine (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .rxd_i(rxd), .mode_i(mode),
    .rx_en_i(rx_en), .rx_dis_i(rx_dis), .rx_rst_i(rx_rst),
    .trig_lvl_i(trig_lvl), .tmo_lim_i(tmo_lim), .tmo_restart_i(tmo_rst),
    .rd_i(rd), .rd_data_o(rd_data), .rd_frm_err_o(frm), .rd_par_err_o(perr),
    .rd_brk_o(brk), .empty_o(empty), .fill_o(fill), .trig_o(trig),
    .tmo_o(tmo), .overrun_o(ovr)
  );

  initial forever begin
    repeat (3) @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  end

  always @(negedge clk) if (ovr) ovr_cnt++;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic line_bit(input logic b);
    rxd = b; clks(64);
  endtask

  // par < 0: no parity bit
  task automatic send(input logic [7:0] d, input int nb, input int par,
                      input int nst, input logic s1, input logic s2);
    @(negedge clk);
    line_bit(1'b0);
    for (int i = 0; i < nb; i++) line_bit(d[i]);
    if (par >= 0) line_bit(par[0]);
    line_bit(s1);
    if (nst == 2) line_bit(s2);
    rxd = 1'b1;
    clks(8);
  endtask

  task automatic expect_char(input string req, input logic [7:0] d,
                             input logic f, input logic p, input logic b);
    chk({req, " not empty"}, empty, 0);
    chk({req, " data"}, rd_data, d);
    chk({req, " frame"}, frm, f);
    chk({req, " parity"}, perr, p);
    chk({req, " break"}, brk, b);
    pulse(rd);
    clks(1);
  endtask

  task automatic flush();
    pulse(rx_rst); clks(2);
  endtask

  task automatic t_reset();
    rst_n = 0; clks(3); rst_n = 1; clks(2);
    chk("R10 reset empty", empty, 1);
    chk("R10 reset fill", fill, 0);
    chk("R9 reset tmo", tmo, 0);
    chk("R7 reset overrun", ovr, 0);
    send(8'hA5, 8, -1, 1, 1, 1);
    chk("R10 disabled after reset stores nothing", empty, 1);
    pulse(rx_en); clks(2);
  endtask

  task automatic t_lengths();
    mode = 8'h20;
    send(8'hC3, 8, -1, 1, 1, 1);
    expect_char("R1 8-bit", 8'hC3, 0, 0, 0);
    mode = 8'h24;
    send(8'h5A, 7, -1, 1, 1, 1);
    expect_char("R1 7-bit", 8'h5A, 0, 0, 0);
    send(8'hFF, 7, -1, 1, 1, 1);
    expect_char("R1 7-bit zero fill", 8'h7F, 0, 0, 0);
    mode = 8'h26;
    send(8'hFF, 6, -1, 1, 1, 1);
    expect_char("R1 6-bit zero fill", 8'h3F, 0, 0, 0);
    send(8'h2A, 6, -1, 1, 1, 1);
    expect_char("R1 6-bit", 8'h2A, 0, 0, 0);
  endtask

  task automatic t_parity();
    mode = 8'h00;
    send(8'h35, 8, ^8'h35, 1, 1, 1);
    expect_char("R2 even good", 8'h35, 0, 0, 0);
    send(8'h35, 8, ~^8'h35, 1, 1, 1);
    expect_char("R2 even bad", 8'h35, 0, 1, 0);
    mode = 8'h08;
    send(8'h35, 8, ~^8'h35, 1, 1, 1);
    expect_char("R2 odd good", 8'h35, 0, 0, 0);
    send(8'h34, 8, ~^8'h35, 1, 1, 1);
    expect_char("R2 odd bad", 8'h34, 0, 1, 0);
    mode = 8'h10;
    send(8'h81, 8, 0, 1, 1, 1);
    expect_char("R2 space good", 8'h81, 0, 0, 0);
    send(8'h81, 8, 1, 1, 1, 1);
    expect_char("R2 space bad", 8'h81, 0, 1, 0);
    mode = 8'h18;
    send(8'h81, 8, 1, 1, 1, 1);
    expect_char("R2 mark good", 8'h81, 0, 0, 0);
    send(8'h81, 8, 0, 1, 1, 1);
    expect_char("R2 mark bad", 8'h81, 0, 1, 0);
    mode = 8'h0C;  // 7 bits, odd
    send(8'h01, 7, 0, 1, 1, 1);
    expect_char("R2 odd 7-bit", 8'h01, 0, 0, 0);
  endtask

  task automatic t_stops();
    mode = 8'h20;
    send(8'h81, 8, -1, 1, 0, 1);
    expect_char("R3 one stop low", 8'h81, 1, 0, 0);
    mode = 8'hA0;
    send(8'h66, 8, -1, 2, 1, 0);
    expect_char("R3 second stop low", 8'h66, 1, 0, 0);
    send(8'h99, 8, -1, 2, 1, 1);
    expect_char("R3 two stops good", 8'h99, 0, 0, 0);
    chk("R3 no extra entries", empty, 1);
  endtask

  task automatic t_break();
    mode = 8'h20;
    @(negedge clk); rxd = 0; clks(64*20); rxd = 1; clks(200);
    chk("R4 one entry for held break", fill, 1);
    expect_char("R4 break", 8'h00, 1, 0, 1);
    send(8'h00, 8, -1, 1, 1, 1);
    expect_char("R4 zero data no break", 8'h00, 0, 0, 0);
  endtask

  task automatic t_false_start();
    mode = 8'h20;
    @(negedge clk); rxd = 0; clks(16); rxd = 1; clks(150);
    chk("R5 glitch rejected", empty, 1);
    send(8'h3C, 8, -1, 1, 1, 1);
    expect_char("R5 next char ok", 8'h3C, 0, 0, 0);
  endtask

  task automatic t_fill();
    mode = 8'h20;
    for (int i = 0; i < 16; i++) begin
      send(8'(8'h10 + i), 8, -1, 1, 1, 1);
      if (i == 2) begin
        trig_lvl = 6'd4; clks(1);
        chk("R8 below level", trig, 0);
        trig_lvl = 6'd3; clks(1);
        chk("R8 at level", trig, 1);
      end
    end
    chk("R6 fill 16", fill, 16);
    trig_lvl = 6'd16; clks(1);
    chk("R8 full at 16", trig, 1);
    trig_lvl = 6'd17; clks(1);
    chk("R8 above depth", trig, 0);
    send(8'hEE, 8, -1, 1, 1, 1);
    chk("R7 one overrun pulse", ovr_cnt, 1);
    chk("R7 fill unchanged", fill, 16);
    for (int i = 0; i < 16; i++)
      expect_char("R6 order", 8'(8'h10 + i), 0, 0, 0);
    chk("R6 empty after drain", empty, 1);
    trig_lvl = 6'd1;
  endtask

  task automatic t_timeout();
    mode = 8'h20; tmo_lim = 8'd1;
    send(8'h42, 8, -1, 1, 1, 1);
    chk("R9 low right after char", tmo, 0);
    clks(150);
    chk("R9 low before limit", tmo, 0);
    clks(150);
    chk("R9 high after limit", tmo, 1);
    pulse(tmo_rst); clks(1);
    chk("R9 restart clears", tmo, 0);
    clks(300);
    chk("R9 high again", tmo, 1);
    expect_char("R9 pop", 8'h42, 0, 0, 0);
    clks(400);
    chk("R9 empty keeps low", tmo, 0);
    tmo_lim = 8'd0;
    send(8'h43, 8, -1, 1, 1, 1);
    clks(700);
    chk("R9 zero limit disabled", tmo, 0);
    flush();
  endtask

  task automatic t_enable();
    mode = 8'h20;
    @(negedge clk); rx_en = 1; rx_dis = 1;
    @(negedge clk); rx_en = 0; rx_dis = 0;
    send(8'h11, 8, -1, 1, 1, 1);
    chk("R10 disable wins", empty, 1);
    pulse(rx_en);
    send(8'h22, 8, -1, 1, 1, 1);
    expect_char("R10 re-enabled", 8'h22, 0, 0, 0);
  endtask

  task automatic t_flush();
    mode = 8'h20;
    send(8'h55, 8, -1, 1, 1, 1);
    send(8'h56, 8, -1, 1, 1, 1);
    chk("R11 two queued", fill, 2);
    flush();
    chk("R11 flushed", empty, 1);
    // abort mid-character: the rest of it must not form a character
    @(negedge clk); rxd = 0; clks(64*3);
    pulse(rx_rst);
    rxd = 1; clks(64*8);
    chk("R11 aborted char dropped", empty, 1);
    send(8'h57, 8, -1, 1, 1, 1);
    expect_char("R11 after flush", 8'h57, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_lengths();
    t_parity();
    t_stops();
    t_break();
    t_false_start();
    t_fill();
    t_timeout();
    t_enable();
    t_flush();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule